// File: doc/BRIEF.md
# Hall-Edge Tachometer Pulse Generator

This block watches the three Hall sensor lines of a brushless motor and emits one positive pulse of fixed length on a single tachometer line for every change on any sensor. The pulse length comes from a count input and does not depend on motor speed. The pulse rate follows the sensor edge rate, so the mean level of the tachometer line is proportional to speed. A later filter or an averaging stage can turn it into a speed estimate.

The sensor lines may be asynchronous to the clock. Each bit passes through a two-flop synchroniser. A registered change detector compares the synchronised sensor word against a stored copy of it. A one-shot counter then times the pulse. A change that arrives while a pulse is high is dropped, so every pulse has exactly the programmed length. At 100 MHz the package default count of 10500 gives a 105 µs pulse.

Top module: `hall_tach_top`

## Requirements
- R1: A change in any single bit of `hall_in` produces one tachometer pulse. If the first rising clock edge that samples the new value is edge k, `tach_out` is high from the third rising edge after k (edge k+3).
- R2: Each pulse stays high for exactly `pulse_width` clock cycles. The count is taken from the value present when the pulse starts. Changing `pulse_width` while a pulse is high does not alter that pulse, but the next pulse uses the new value.
- R3: A change of two or three sensor bits in the same cycle produces a single pulse.
- R4: A sensor change whose detection falls while `tach_out` is high is ignored. It does not restart or lengthen the pulse, and no pulse follows it later. A change detected in the cycle directly after the pulse ends starts a new pulse, leaving a one-cycle low gap.
- R5: While `pulse_width` is 0, sensor changes produce no pulse and `tach_out` stays low.
- R6: While `rst` is high, `tach_out` is low. After reset is released, the stored sensor copy holds the sensor value seen during reset, so no pulse appears unless the sensors change after release.
- R7: The package default width of 10500 cycles gives a 105 µs pulse at a 100 MHz clock.
- R8: Sensor changes spaced more than the pulse width apart each produce one pulse. The number of high cycles over a run is therefore the number of changes times the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | N_HALL (3) | Raw Hall sensor bits, may be asynchronous |
| pulse_width | input | CNT_W (16) | Pulse length in clock cycles; 0 disables pulses |
| tach_out | output | 1 | Registered tachometer pulse line |

## Verification
The one-shot assertions take for granted that `pulse_width` is a quasi-static setting. The bench therefore changes it only while a pulse is high or while the sensors have been quiet for many cycles. The assertions also rely on reset lasting longer than the synchroniser depth, with the sensors steady around reset release, so the stored sensor copy starts from a settled value. The bench drives the sensors and the width on falling clock edges and holds reset for six cycles. It changes the sensor value only inside reset, never across its release.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int HALL_BITS     = 3;
  localparam int CNT_BITS      = 16;
  localparam int SYNC_DEPTH    = 2;
  localparam int CLK_MHZ       = 100;
  localparam int PULSE_NS      = 105000;
  localparam int DEFAULT_WIDTH = (PULSE_NS * CLK_MHZ) / 1000;
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int N_BITS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic [N_BITS-1:0] async_i,
  output logic [N_BITS-1:0] sync_o
);
  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/hall_edge_det.sv
module hall_edge_det #(
  parameter int N_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BITS-1:0] sync_i,
  output logic              edge_o
);
  logic [N_BITS-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= sync_i;
      edge_o <= 1'b0;
    end else begin
      hist   <= sync_i;
      edge_o <= |(sync_i ^ hist);
    end
  end
endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      remain  <= ZERO;
    end else if (!pulse_o) begin
      if (trig_i && (width_i != ZERO)) begin
        pulse_o <= 1'b1;
        remain  <= width_i - ONE;
      end
    end else if (remain == ZERO) begin
      pulse_o <= 1'b0;
    end else begin
      remain <= remain - ONE;
    end
  end

  // R1: a pulse only begins after a detected sensor change with a nonzero width
  assert_rise_from_edge_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> ($past(trig_i) && ($past(width_i) != ZERO)));

  // R4: an active pulse with time left is never cut short or restarted
  assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && (remain != ZERO)) |=> pulse_o);

  // R2: a pulse ends only once its count has run out
  assert_end_on_count_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> ($past(remain) == ZERO));

  // R5: a zero width keeps the line low
  assert_zero_width_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && (width_i == ZERO)) |=> !pulse_o);
endmodule

// File: rtl/hall_tach_top.sv
module hall_tach_top #(
  parameter int N_HALL = tach_pkg::HALL_BITS,
  parameter int CNT_W  = tach_pkg::CNT_BITS,
  parameter int STAGES = tach_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_HALL-1:0] hall_in,
  input  logic [CNT_W-1:0]  pulse_width,
  output logic              tach_out
);
  logic [N_HALL-1:0] hall_s;
  logic              change;

  hall_sync #(.N_BITS(N_HALL), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .async_i(hall_in),
    .sync_o (hall_s)
  );

  hall_edge_det #(.N_BITS(N_HALL)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .sync_i(hall_s),
    .edge_o(change)
  );

  tach_oneshot #(.CNT_W(CNT_W)) u_shot (
    .clk    (clk),
    .rst    (rst),
    .trig_i (change),
    .width_i(pulse_width),
    .pulse_o(tach_out)
  );
endmodule

// File: tb/hall_tach_top_tb.sv
`timescale 1ns/1ps
module hall_tach_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  hall = 3'b000;
  logic [15:0] width = 16'd20;
  logic        tach;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_end = 0;
  int high_cnt = 0;
  bit done = 1'b0;

  int    exp_start[$];
  int    exp_width[$];
  string exp_tag[$];

  hall_tach_top u_dut (
    .clk(clk), .rst(rst), .hall_in(hall), .pulse_width(width), .tach_out(tach)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: called on a falling edge, predicts the pulse from the requirements
  task automatic set_hall(input logic [2:0] v, input string tag);
    int st;
    if (v != hall) begin
      st = cyc + 4;
      if (width != 0 && st >= last_end + 1) begin
        exp_start.push_back(st);
        exp_width.push_back(int'(width));
        exp_tag.push_back(tag);
        last_end = st + int'(width);
      end
    end
    hall = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  logic prev_t = 1'b0;
  int   rise_c = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (tach) high_cnt++;
      if (tach && !prev_t) rise_c = cyc;
      if (!tach && prev_t) begin
        if (exp_start.size() == 0) begin
          check(1'b0, "R4/R6 unexpected pulse", rise_c, -1);
        end else begin
          int s; int w; string t;
          s = exp_start.pop_front();
          w = exp_width.pop_front();
          t = exp_tag.pop_front();
          check(rise_c == s, {t, " start"}, rise_c, s);
          check(cyc - rise_c == w, {t, " width"}, cyc - rise_c, w);
        end
      end
      prev_t = tach;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end

  initial begin
    int hc;
    bit quiet;
    // R6: reset state, sensor changes inside reset
    idle(3);
    check(tach == 1'b0, "R6 low in reset", tach, 0);
    hall = 3'b101;
    idle(3);
    check(tach == 1'b0, "R6 low in reset after sensor move", tach, 0);
    rst = 1'b0;
    last_end = cyc;
    idle(30);
    check(tach == 1'b0 && exp_start.size() == 0, "R6 no pulse after release", tach, 0);

    // R1: single-bit changes on each bit
    set_hall(3'b100, "R1 bit0"); idle(40);
    set_hall(3'b110, "R1 bit1"); idle(40);
    set_hall(3'b010, "R1 bit2"); idle(40);
    // R3: all bits and two bits at once
    set_hall(3'b101, "R3 three bits"); idle(40);
    set_hall(3'b011, "R3 two bits");   idle(40);

    // R4: changes during an active pulse are ignored
    set_hall(3'b001, "R4 first"); idle(3);
    set_hall(3'b000, "R4 ignored"); idle(10);
    set_hall(3'b010, "R4 ignored"); idle(50);
    check(exp_start.size() == 0, "R4 only one pulse", exp_start.size(), 0);

    // R4 boundary: spacing width+1 accepted, width rejected
    set_hall(3'b011, "R4 gap ref"); idle(21);
    set_hall(3'b111, "R4 gap one"); idle(60);
    set_hall(3'b110, "R4 edge ref"); idle(20);
    set_hall(3'b100, "R4 late ignored"); idle(60);
    check(exp_start.size() == 0, "R4 boundary pulses", exp_start.size(), 0);

    // R2: width change during a pulse does not alter it
    set_hall(3'b101, "R2 old width"); idle(8);
    width = 16'd50; idle(60);
    set_hall(3'b001, "R2 new width"); idle(80);
    width = 16'd1;
    set_hall(3'b011, "R2 width one"); idle(20);

    // R5: zero width
    width = 16'd0;
    quiet = 1'b1;
    set_hall(3'b010, "R5");
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tach) quiet = 1'b0; end
    set_hall(3'b110, "R5");
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tach) quiet = 1'b0; end
    check(quiet, "R5 line stays low", int'(!quiet), 0);

    // R8: periodic train, high time equals changes times width
    width = 16'd20;
    idle(10);
    hc = high_cnt;
    for (int i = 0; i < 8; i++) begin
      set_hall(hall ^ 3'b001, "R8 train");
      idle(30);
    end
    idle(20);
    check(high_cnt - hc == 8 * 20, "R8 high cycles", high_cnt - hc, 160);

    // R7: default width gives 105 us at 100 MHz
    width = 16'(tach_pkg::DEFAULT_WIDTH);
    check(tach_pkg::DEFAULT_WIDTH == 10500, "R7 default count", tach_pkg::DEFAULT_WIDTH, 10500);
    set_hall(hall ^ 3'b100, "R7 default pulse");
    idle(10600);

    check(exp_start.size() == 0 && tach == 1'b0, "R2 scoreboard drained", exp_start.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule